// File: doc/BRIEF.md
# Folded Address Memory Port with Hardware Stack

This block sits between a small 8-bit processor core and its byte-wide storage. The core hands it one operation at a time: a byte or a 16-bit load, a byte or a 16-bit store, or a byte or a 16-bit stack transfer. The block translates each 16-bit logical address into a physical one by folding two low regions onto small repeated windows. It then runs one byte cycle per byte against a synchronous store and pulses `done` when the result is ready. The storage is modelled inside the block as behavioural byte arrays.

The block owns the 8-bit stack pointer. Stack transfers always address page one (physical `0x0100 + sp`). A store to the stack uses the current pointer and then moves it down. A load from the stack first moves the pointer up and then reads, so the two are exact inverses. A 16-bit stack store, used for return addresses, sends the high byte first. The matching 16-bit stack load collects the low byte first.

The control is one state machine with four states. `ST_IDLE` goes to `ST_FIRST` when `req` is high. `ST_FIRST` goes to `ST_SECOND` for a 16-bit operation and to `ST_REPLY` otherwise. `ST_SECOND` always goes to `ST_REPLY`, and `ST_REPLY` always goes back to `ST_IDLE`. `ST_FIRST` and `ST_SECOND` are the byte cycles. `ST_REPLY` is the cycle in which `done` is high.

Top module: `mirrored_mem_port`

## Requirements
- R1: A logical address below 0x2000 is translated to (address AND 0x07FF), so every 2 KB slice of that range reaches the same bytes.
- R2: A logical address from 0x2000 through 0x3FFF is translated to (address AND 0x2007), so an eight-byte window repeats across that range.
- R3: A logical address of 0x4000 or above is presented unchanged on `phys_addr`. The backing storage there holds 1 KB, selected by physical address bits 9..0.
- R4: A 16-bit load or store (op 1, op 3) keeps the low byte at logical address A and the high byte at A+1. A+1 wraps within 16 bits, and each byte's address is folded on its own.
- R5: Op codes: 0 byte load, 1 16-bit load, 2 byte store, 3 16-bit store, 4 byte push, 5 byte pull, 6 16-bit push, 7 16-bit pull. An op is accepted on a clock edge where `req` is high and the block is idle. `done` is high for exactly one cycle: the second cycle after acceptance for byte ops and the third for 16-bit ops. During `done`, a load or pull shows its result on `rdata`, zero-extended for byte ops. At all other times, and for stores, `rdata` is zero.
- R6: After reset, `sp` is 0xFD and `done` and `phys_act` are low.
- R7: A byte push writes `wdata[7:0]` at 0x0100+sp, then sp decreases by one.
- R8: A byte pull adds one to sp, then reads 0x0100+sp (the updated value).
- R9: A 16-bit push writes `wdata[15:8]` at 0x0100+sp and `wdata[7:0]` at the next lower stack slot, leaving sp two lower. A 16-bit pull reads the low byte and then the high byte from two rising slots, leaving sp two higher, and so undoes the push.
- R10: sp wraps modulo 256: a push at 0x00 leaves 0xFF, and a pull at 0xFF reads slot 0x00.
- R11: `req` seen while an op is in progress has no effect. No storage, sp or output changes because of it.
- R12: `phys_act` is high exactly during the byte cycles, and `phys_addr` then shows the physical byte address; both are zero otherwise. sp changes only at the end of a stack byte cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Operation request |
| op | input | 3 | Operation code (see R5) |
| addr | input | 16 | Logical address for loads and stores |
| wdata | input | 16 | Store or push data; byte ops use bits 7..0 |
| rdata | output | 16 | Load or pull result, valid while `done` |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 8 | Current stack pointer |
| phys_addr | output | 16 | Physical address of the current byte cycle |
| phys_act | output | 1 | High during byte cycles |

## Verification
A wrong fold or a wrong stack offset shows on `phys_addr` in the byte cycle itself, one cycle after acceptance. Corrupted storage shows on `rdata` only when a later load returns to that location, so each store is followed closely by loads through aliased addresses. A stale or mis-stepped stack pointer appears on `sp` in the cycle after the faulty byte cycle. A wrong state sequence moves the `done` pulse by at least one cycle, and the per-cycle reference comparison catches that in the same clock.

// File: rtl/mmp_pkg.sv
package mmp_pkg;

    typedef enum logic [2:0] {
        OP_RD8    = 3'd0,
        OP_RD16   = 3'd1,
        OP_WR8    = 3'd2,
        OP_WR16   = 3'd3,
        OP_PUSH8  = 3'd4,
        OP_PULL8  = 3'd5,
        OP_PUSH16 = 3'd6,
        OP_PULL16 = 3'd7
    } mmp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_REPLY  = 2'd3
    } mmp_state_e;

    function automatic logic op_wide(input mmp_op_e o);
        return (o == OP_RD16) || (o == OP_WR16) || (o == OP_PUSH16) || (o == OP_PULL16);
    endfunction

    function automatic logic op_reads(input mmp_op_e o);
        return (o == OP_RD8) || (o == OP_RD16) || (o == OP_PULL8) || (o == OP_PULL16);
    endfunction

    function automatic logic op_stack(input mmp_op_e o);
        return (o == OP_PUSH8) || (o == OP_PULL8) || (o == OP_PUSH16) || (o == OP_PULL16);
    endfunction

    function automatic logic op_pull(input mmp_op_e o);
        return (o == OP_PULL8) || (o == OP_PULL16);
    endfunction

endpackage

// File: rtl/mmp_addr_fold.sv
module mmp_addr_fold #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RAM_END  = 16'h2000,
    parameter logic [ADDR_W-1:0] WIN_END  = 16'h4000,
    parameter logic [ADDR_W-1:0] RAM_MASK = 16'h07FF,
    parameter logic [ADDR_W-1:0] WIN_MASK = 16'h2007
) (
    input  logic [ADDR_W-1:0] logical_i,
    output logic [ADDR_W-1:0] physical_o
);

    always_comb begin
        if (logical_i < RAM_END) begin
            physical_o = logical_i & RAM_MASK;
        end else if (logical_i < WIN_END) begin
            physical_o = logical_i & WIN_MASK;
        end else begin
            physical_o = logical_i;
        end
    end

endmodule

// File: rtl/mmp_stack_ptr.sv
module mmp_stack_ptr #(
    parameter int             SP_W     = 8,
    parameter logic [SP_W-1:0] SP_RESET = 8'hFD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_up,
    input  logic            step_down,
    output logic [SP_W-1:0] sp_o
);

    logic [SP_W-1:0] sp_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_r <= SP_RESET;
        end else if (step_up) begin
            sp_r <= sp_r + SP_W'(1);
        end else if (step_down) begin
            sp_r <= sp_r - SP_W'(1);
        end
    end

    assign sp_o = sp_r;

    // R12
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up || step_down) |=> $stable(sp_o));

    // R10
    sp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_down) |=> !$stable(sp_o));

endmodule

// File: rtl/mmp_byte_store.sv
module mmp_byte_store #(
    parameter int                ADDR_W  = 16,
    parameter int                RAM_AW  = 11,
    parameter int                WIN_AW  = 3,
    parameter int                HI_AW   = 10,
    parameter logic [ADDR_W-1:0] RAM_END = 16'h2000,
    parameter logic [ADDR_W-1:0] WIN_END = 16'h4000
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        q_o
);

    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int WIN_DEPTH = 1 << WIN_AW;
    localparam int HI_DEPTH  = 1 << HI_AW;

    logic [7:0] ram_mem [RAM_DEPTH];
    logic [7:0] win_mem [WIN_DEPTH];
    logic [7:0] hi_mem  [HI_DEPTH];

    logic in_ram;
    logic in_win;
    logic [RAM_AW-1:0] ram_idx;
    logic [WIN_AW-1:0] win_idx;
    logic [HI_AW-1:0]  hi_idx;

    always_comb begin
        in_ram  = addr_i < RAM_END;
        in_win  = !in_ram && (addr_i < WIN_END);
        ram_idx = addr_i[RAM_AW-1:0];
        win_idx = addr_i[WIN_AW-1:0];
        hi_idx  = addr_i[HI_AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            if (in_ram) begin
                ram_mem[ram_idx] <= wdata_i;
            end else if (in_win) begin
                win_mem[win_idx] <= wdata_i;
            end else begin
                hi_mem[hi_idx] <= wdata_i;
            end
        end
        if (in_ram) begin
            q_o <= ram_mem[ram_idx];
        end else if (in_win) begin
            q_o <= win_mem[win_idx];
        end else begin
            q_o <= hi_mem[hi_idx];
        end
    end

endmodule

// File: rtl/mirrored_mem_port.sv
module mirrored_mem_port
    import mmp_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                SP_W       = 8,
    parameter logic [SP_W-1:0]   SP_RESET   = 8'hFD,
    parameter logic [7:0]        STACK_PAGE = 8'h01,
    parameter int                RAM_AW     = 11,
    parameter int                WIN_AW     = 3,
    parameter int                HI_AW      = 10,
    parameter logic [ADDR_W-1:0] RAM_END    = 16'h2000,
    parameter logic [ADDR_W-1:0] WIN_END    = 16'h4000,
    parameter logic [ADDR_W-1:0] RAM_MASK   = 16'h07FF,
    parameter logic [ADDR_W-1:0] WIN_MASK   = 16'h2007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              done,
    output logic [SP_W-1:0]   sp,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              phys_act
);

    localparam logic [ADDR_W-1:0] RAM_LIMIT = ADDR_W'(1 << RAM_AW);

    mmp_state_e        state, state_nx;
    mmp_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wdata_q;
    logic [7:0]        lo_q;

    logic              in_first, in_second;
    logic              wide, reads, stacky, pulls;
    logic [ADDR_W-1:0] logical_byte;
    logic [ADDR_W-1:0] folded_byte;
    logic [SP_W-1:0]   stack_slot;
    logic [ADDR_W-1:0] byte_addr;
    logic [7:0]        byte_wdata;
    logic              byte_we;
    logic              sp_up, sp_down;
    logic [7:0]        store_q;

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_RD8;
            addr_q  <= '0;
            wdata_q <= '0;
            lo_q    <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req) begin
                op_q    <= mmp_op_e'(op);
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (state == ST_SECOND) begin
                lo_q <= store_q;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = req ? ST_FIRST : ST_IDLE;
            ST_FIRST:  state_nx = wide ? ST_SECOND : ST_REPLY;
            ST_SECOND: state_nx = ST_REPLY;
            ST_REPLY:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // operation attributes
    always_comb begin
        wide   = op_wide(op_q);
        reads  = op_reads(op_q);
        stacky = op_stack(op_q);
        pulls  = op_pull(op_q);
    end

    mmp_addr_fold #(
        .ADDR_W  (ADDR_W),
        .RAM_END (RAM_END),
        .WIN_END (WIN_END),
        .RAM_MASK(RAM_MASK),
        .WIN_MASK(WIN_MASK)
    ) u_fold (
        .logical_i (logical_byte),
        .physical_o(folded_byte)
    );

    mmp_stack_ptr #(
        .SP_W    (SP_W),
        .SP_RESET(SP_RESET)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (sp_up),
        .step_down(sp_down),
        .sp_o     (sp)
    );

    mmp_byte_store #(
        .ADDR_W (ADDR_W),
        .RAM_AW (RAM_AW),
        .WIN_AW (WIN_AW),
        .HI_AW  (HI_AW),
        .RAM_END(RAM_END),
        .WIN_END(WIN_END)
    ) u_store (
        .clk    (clk),
        .addr_i (byte_addr),
        .we_i   (byte_we),
        .wdata_i(byte_wdata),
        .q_o    (store_q)
    );

    // outputs and byte-cycle controls
    always_comb begin
        in_first     = (state == ST_FIRST);
        in_second    = (state == ST_SECOND);
        phys_act     = in_first || in_second;
        logical_byte = addr_q + ADDR_W'(in_second);
        stack_slot   = pulls ? (sp + SP_W'(1)) : sp;
        byte_addr    = stacky ? ADDR_W'({STACK_PAGE, stack_slot}) : folded_byte;
        phys_addr    = phys_act ? byte_addr : '0;
        byte_we      = phys_act && !reads;
        sp_up        = phys_act && stacky && pulls;
        sp_down      = phys_act && stacky && !pulls;
        if (op_q == OP_PUSH16) begin
            byte_wdata = in_first ? wdata_q[15:8] : wdata_q[7:0];
        end else begin
            byte_wdata = in_first ? wdata_q[7:0] : wdata_q[15:8];
        end
        done  = (state == ST_REPLY);
        rdata = '0;
        if (done && reads) begin
            rdata = wide ? {store_q, lo_q} : {8'h00, store_q};
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    wide_two_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wide) |-> ($past(phys_act) && $past(phys_act, 2)));

    // R5
    narrow_one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide) |-> ($past(phys_act) && !$past(phys_act, 2)));

    // R7
    stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_act && stacky) |-> (phys_addr[ADDR_W-1:SP_W] == STACK_PAGE));

    // R1
    fold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_act && !stacky && logical_byte < RAM_END) |-> (phys_addr < RAM_LIMIT));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(addr_q) && $stable(wdata_q)));

endmodule

// File: tb/mirrored_mem_port_tb.sv
module mirrored_mem_port_tb_top;

    typedef struct {
        bit        act;
        bit [15:0] phys;
        bit        dn;
        bit [15:0] rd;
        bit [7:0]  spv;
        string     tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] addr = 16'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        done;
    logic [7:0]  sp;
    logic [15:0] phys_addr;
    logic        phys_act;

    int vectors = 0;
    int misses = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    exp_t       exp_q[$];
    bit [7:0]   mem[int];
    bit [7:0]   msp = 8'hFD;

    always #10 clk = ~clk;

    mirrored_mem_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .op       (op),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .done     (done),
        .sp       (sp),
        .phys_addr(phys_addr),
        .phys_act (phys_act)
    );

    function automatic bit [15:0] fold_f(input bit [15:0] a);
        if (a < 16'h2000) return a & 16'h07FF;
        if (a < 16'h4000) return a & 16'h2007;
        return a;
    endfunction

    function automatic int key_f(input bit [15:0] p);
        if (p >= 16'h4000) return 32'h4000 + int'(p & 16'h03FF);
        return int'(p);
    endfunction

    function automatic bit [7:0] rdm(input bit [15:0] p);
        if (mem.exists(key_f(p))) return mem[key_f(p)];
        return 8'h00;
    endfunction

    function automatic void add(input bit a, input bit [15:0] p, input bit d,
                                input bit [15:0] r, input bit [7:0] s, input string t);
        exp_t e;
        e.act = a; e.phys = p; e.dn = d; e.rd = r; e.spv = s; e.tag = t;
        exp_q.push_back(e);
    endfunction

    function automatic void build(input bit [2:0] o, input bit [15:0] a,
                                  input bit [15:0] w, input string t);
        bit [15:0] p0, p1;
        bit [7:0]  b0, b1;
        add(0, 16'h0, 0, 16'h0, msp, t);
        case (o)
            3'd0: begin
                p0 = fold_f(a);
                add(1, p0, 0, 16'h0, msp, t);
                add(0, 16'h0, 1, {8'h00, rdm(p0)}, msp, t);
            end
            3'd1: begin
                p0 = fold_f(a); p1 = fold_f(a + 16'd1);
                add(1, p0, 0, 16'h0, msp, t);
                add(1, p1, 0, 16'h0, msp, t);
                add(0, 16'h0, 1, {rdm(p1), rdm(p0)}, msp, t);
            end
            3'd2: begin
                p0 = fold_f(a);
                add(1, p0, 0, 16'h0, msp, t);
                mem[key_f(p0)] = w[7:0];
                add(0, 16'h0, 1, 16'h0, msp, t);
            end
            3'd3: begin
                p0 = fold_f(a); p1 = fold_f(a + 16'd1);
                add(1, p0, 0, 16'h0, msp, t);
                mem[key_f(p0)] = w[7:0];
                add(1, p1, 0, 16'h0, msp, t);
                mem[key_f(p1)] = w[15:8];
                add(0, 16'h0, 1, 16'h0, msp, t);
            end
            3'd4: begin
                p0 = {8'h01, msp};
                add(1, p0, 0, 16'h0, msp, t);
                mem[key_f(p0)] = w[7:0];
                msp = msp - 8'd1;
                add(0, 16'h0, 1, 16'h0, msp, t);
            end
            3'd5: begin
                p0 = {8'h01, 8'(msp + 8'd1)};
                add(1, p0, 0, 16'h0, msp, t);
                msp = msp + 8'd1;
                add(0, 16'h0, 1, {8'h00, rdm(p0)}, msp, t);
            end
            3'd6: begin
                p0 = {8'h01, msp};
                add(1, p0, 0, 16'h0, msp, t);
                mem[key_f(p0)] = w[15:8];
                msp = msp - 8'd1;
                p1 = {8'h01, msp};
                add(1, p1, 0, 16'h0, msp, t);
                mem[key_f(p1)] = w[7:0];
                msp = msp - 8'd1;
                add(0, 16'h0, 1, 16'h0, msp, t);
            end
            default: begin
                p0 = {8'h01, 8'(msp + 8'd1)};
                add(1, p0, 0, 16'h0, msp, t);
                b0 = rdm(p0);
                msp = msp + 8'd1;
                p1 = {8'h01, 8'(msp + 8'd1)};
                add(1, p1, 0, 16'h0, msp, t);
                b1 = rdm(p1);
                msp = msp + 8'd1;
                add(0, 16'h0, 1, {b1, b0}, msp, t);
            end
        endcase
    endfunction

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (running && rst_n) begin
            exp_t e;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
            end else begin
                e.act = 0; e.phys = 16'h0; e.dn = 0; e.rd = 16'h0; e.spv = msp; e.tag = "R12";
            end
            vectors++;
            if (phys_act !== e.act || phys_addr !== e.phys || done !== e.dn ||
                rdata !== e.rd || sp !== e.spv) begin
                misses++;
                $display("FAIL %s: act=%0b/%0b phys=%h/%h done=%0b/%0b rdata=%h/%h sp=%h/%h",
                         e.tag, phys_act, e.act, phys_addr, e.phys, done, e.dn,
                         rdata, e.rd, sp, e.spv);
            end
        end
    end

    task automatic issue(input bit [2:0] o, input bit [15:0] a, input bit [15:0] w,
                         input string t);
        @(posedge clk); #1;
        req = 1'b1; op = o; addr = a; wdata = w;
        build(o, a, w, t);
        @(posedge clk); #1;
        req = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // byte op A, with op B requested throughout its busy cycles (R11)
    task automatic issue_busy(input bit [2:0] o, input bit [15:0] a, input bit [15:0] w,
                              input bit [2:0] bo, input bit [15:0] ba, input bit [15:0] bw);
        @(posedge clk); #1;
        req = 1'b1; op = o; addr = a; wdata = w;
        build(o, a, w, "R11");
        @(posedge clk); #1;
        op = bo; addr = ba; wdata = bw;
        @(posedge clk); #1;
        @(posedge clk); #1;
        req = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        vectors++;
        if (sp !== 8'hFD || done !== 1'b0 || phys_act !== 1'b0) begin
            misses++;
            $display("FAIL R6: sp=%h done=%0b act=%0b expected sp=fd done=0 act=0",
                     sp, done, phys_act);
        end
        running = 1'b1;

        // R1 low RAM mirroring
        issue(3'd2, 16'h0005, 16'h0011, "R1");
        issue(3'd0, 16'h0805, 16'h0000, "R1");
        issue(3'd0, 16'h1805, 16'h0000, "R1");
        // R2 eight-byte window
        issue(3'd2, 16'h2003, 16'h005A, "R2");
        issue(3'd0, 16'h3FFB, 16'h0000, "R2");
        issue(3'd0, 16'h2FFB, 16'h0000, "R2");
        // R3 pass-through
        issue(3'd2, 16'h8123, 16'h0077, "R3");
        issue(3'd0, 16'h8123, 16'h0000, "R3");
        issue(3'd0, 16'h4123, 16'h0000, "R3");
        // R4 little-endian pairs
        issue(3'd3, 16'h0300, 16'hBEEF, "R4");
        issue(3'd0, 16'h0300, 16'h0000, "R4");
        issue(3'd0, 16'h0301, 16'h0000, "R4");
        issue(3'd1, 16'h0B00, 16'h0000, "R4");
        issue(3'd3, 16'h07FF, 16'h1234, "R4");
        issue(3'd0, 16'h0000, 16'h0000, "R4");
        issue(3'd3, 16'h1FFF, 16'h5678, "R4");
        issue(3'd0, 16'h2008, 16'h0000, "R4");
        issue(3'd1, 16'h0FFF, 16'h0000, "R5");
        // R7, R8, R9 stack
        issue(3'd4, 16'h0000, 16'h00A1, "R7");
        issue(3'd6, 16'h0000, 16'hC0DE, "R9");
        issue(3'd0, 16'h01FC, 16'h0000, "R9");
        issue(3'd0, 16'h01FB, 16'h0000, "R9");
        issue(3'd7, 16'h0000, 16'h0000, "R9");
        issue(3'd5, 16'h0000, 16'h0000, "R8");
        // R10 wrap both ways
        issue(3'd2, 16'h01FE, 16'h0031, "R10");
        issue(3'd2, 16'h01FF, 16'h0032, "R10");
        issue(3'd2, 16'h0100, 16'h0033, "R10");
        issue(3'd5, 16'h0000, 16'h0000, "R8");
        issue(3'd5, 16'h0000, 16'h0000, "R10");
        issue(3'd5, 16'h0000, 16'h0000, "R10");
        issue(3'd4, 16'h0000, 16'h0099, "R10");
        issue(3'd5, 16'h0000, 16'h0000, "R10");
        issue(3'd6, 16'h0000, 16'hABCD, "R10");
        issue(3'd7, 16'h0000, 16'h0000, "R10");
        // R11 requests while busy
        issue_busy(3'd2, 16'h0010, 16'h0001, 3'd2, 16'h0010, 16'h00FF);
        issue(3'd0, 16'h0010, 16'h0000, "R11");
        issue_busy(3'd0, 16'h0010, 16'h0000, 3'd4, 16'h0000, 16'h00EE);
        issue(3'd0, {8'h01, msp}, 16'h0000, "R11");
        // R5 mixed patterns through aliased addresses
        for (int i = 0; i < 12; i++) begin
            bit [15:0] a;
            bit [15:0] w;
            a = 16'((i * 343 + 64) % 16'h1F00);
            w = 16'(i * 16'h1111) ^ 16'hA5C3;
            issue(3'd3, a, w, "R5");
            issue(3'd1, a ^ 16'h1800, 16'h0000, "R5");
            issue(3'd0, a + 16'd1, 16'h0000, "R12");
        end
        repeat (3) @(posedge clk);
        summary();
    end

endmodule